// File: doc/BRIEF.md
# Line-Rate Vertical-Shift Reject Generator

This block sits between a sensor timing generator and a correlated sampling front end. It receives two line-rate pulses, both synchronous to the pixel clock. The clamp pulse drives the DC-restore clamp. The calibration pulse marks the optical-black pixels that black-level calibration uses. From these two pulses the block builds an internal reject window that covers the vertical shift time, so that the sampling stage is cut off from its input pins during that time. It also supplies registered copies of both pulses, aligned in time with the reject window.

Two configuration bits control the window. One bit enables rejection. The other bit chooses which pulse opens the window with its trailing edge; the other pulse then closes the window with its leading edge. A third bit selects the alternate one-shot clocking mode, and rejection is inhibited while that mode is selected. The block also watches for the two pulses being high in the same cycle. If that happens, it sets a sticky error flag.

Configuration is written through a one-cycle write strobe. A written value is used from the next window-opening edge onward, so a window that is already open is never cut short or changed by a write.

Top module: `vsreject_top`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `rejectOut`, `clampEn`, `calWindow` and `overlapErr` are 0 and the configuration word is 000.
- R2: `clampEn` and `calWindow` each equal the level of `clampIn` and `calIn` sampled at the previous rising clock edge.
- R3: If `clampIn` and `calIn` are both 1 at a clock edge, `overlapErr` is 1 from the next cycle onward and stays 1 until reset.
- R4: With configuration bit 1 (swap) at 0, `rejectOut` rises in the same cycle that `calWindow` falls. It falls in the same cycle that `clampEn` rises.
- R5: With swap at 1, the roles are exchanged. `rejectOut` rises with the fall of `clampEn` and falls with the rise of `calWindow`.
- R6: With configuration bit 0 (reject enable) at 0 when the opening edge is sampled, no window opens and `rejectOut` stays 0.
- R7: With configuration bit 2 (one-shot mode) at 1 when the opening edge is sampled, no window opens and `rejectOut` stays 0.
- R8: After reset, no window opens until the opening pulse has been seen high and then low. A pulse that is already low, or a closing pulse seen on its own, does not open a window.
- R9: A configuration write made while a window is open leaves that window unchanged. The new value is used from the next opening edge.
- R10: If either pulse rises while a window is open, the window closes. This includes the opening pulse rising again before the closing pulse arrives.
- R11: `rejectOut` is never 1 in a cycle where `clampEn` or `calWindow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe, one cycle |
| cfgWrData | input | 3 | Configuration word: bit0 reject enable, bit1 swap roles, bit2 one-shot mode |
| clampIn | input | 1 | Line-rate clamp pulse |
| calIn | input | 1 | Line-rate calibration pulse |
| rejectOut | output | 1 | Vertical-shift reject; disconnects the sampling front end |
| clampEn | output | 1 | Clamp strobe, one-cycle delayed copy of `clampIn` |
| calWindow | output | 1 | Calibration window strobe, one-cycle delayed copy of `calIn` |
| overlapErr | output | 1 | Sticky flag for both pulses being high in the same cycle |

## Verification
On every cycle, the bound checker verifies four things: the one-cycle alignment of both strobes, the sticky overlap flag, that `rejectOut` never overlaps either strobe, and that every rising edge of `rejectOut` coincides with the falling strobe that the configuration selects while rejection is enabled. Some behaviour can only be shown by directed line sequences in the bench. This covers the startup case, where only a partial line is seen. It also covers a reject-enable write and a swap write made in mid-window, a repeated opening pulse, and the exact cycle in which the window closes.

// File: rtl/vsreject_pkg.sv
package vsreject_pkg;

  localparam int CFG_W           = 3;
  localparam int CFG_REJ_BIT     = 0;
  localparam int CFG_SWAP_BIT    = 1;
  localparam int CFG_ONESHOT_BIT = 2;

  // Field order follows the configuration word bit positions (MSB first).
  typedef struct packed {
    logic oneShot;
    logic swapRoles;
    logic rejectEn;
  } cfg_t;

  // Edge strobes derived from raw inputs versus their registered copies.
  typedef struct packed {
    logic clampRise;
    logic clampFall;
    logic calRise;
    logic calFall;
  } edges_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic openWin;
    logic closeWin;
  } winCtl_t;

endpackage

// File: rtl/vsreject_cfg.sv
module vsreject_cfg
  import vsreject_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output cfg_t             cfgShadow
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgShadow <= '0;
    end else if (wrEn) begin
      cfgShadow <= cfg_t'(wrData);
    end
  end

endmodule

// File: rtl/vsreject_ctrl.sv
module vsreject_ctrl
  import vsreject_pkg::*;
(
  input  cfg_t    cfgShadow,
  input  edges_t  edges,
  input  logic    clampNow,
  input  logic    calNow,
  input  logic    windowOpen,
  output winCtl_t winCtl
);

  logic openerFall;
  logic closerHigh;
  logic armed;
  logic anyRise;

  // Opening pulse: calibration when not swapped, clamp when swapped.
  always_comb begin
    if (cfgShadow.swapRoles) begin
      openerFall = edges.clampFall;
      closerHigh = calNow;
    end else begin
      openerFall = edges.calFall;
      closerHigh = clampNow;
    end
  end

  // The configuration is sampled only at the opening edge, so writes made
  // mid-window are used from the next line onward.
  assign armed   = cfgShadow.rejectEn && !cfgShadow.oneShot;
  assign anyRise = edges.clampRise || edges.calRise;

  always_comb begin
    winCtl          = '0;
    winCtl.openWin  = !windowOpen && armed && openerFall && !closerHigh;
    winCtl.closeWin = windowOpen && anyRise;
  end

endmodule

// File: rtl/vsreject_datapath.sv
module vsreject_datapath
  import vsreject_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clampIn,
  input  logic    calIn,
  input  winCtl_t winCtl,
  output edges_t  edges,
  output logic    windowOpen,
  output logic    clampEn,
  output logic    calWindow,
  output logic    overlapErr
);

  logic clampQ;
  logic calQ;
  logic rejectQ;
  logic overlapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampQ <= 1'b0;
      calQ   <= 1'b0;
    end else begin
      clampQ <= clampIn;
      calQ   <= calIn;
    end
  end

  always_comb begin
    edges.clampRise = clampIn && !clampQ;
    edges.clampFall = !clampIn && clampQ;
    edges.calRise   = calIn && !calQ;
    edges.calFall   = !calIn && calQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rejectQ <= 1'b0;
    end else if (winCtl.openWin) begin
      rejectQ <= 1'b1;
    end else if (winCtl.closeWin) begin
      rejectQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overlapQ <= 1'b0;
    end else if (clampIn && calIn) begin
      overlapQ <= 1'b1;
    end
  end

  assign windowOpen = rejectQ;
  assign clampEn    = clampQ;
  assign calWindow  = calQ;
  assign overlapErr = overlapQ;

endmodule

// File: rtl/vsreject_top.sv
module vsreject_top
  import vsreject_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             clampIn,
  input  logic             calIn,
  output logic             rejectOut,
  output logic             clampEn,
  output logic             calWindow,
  output logic             overlapErr
);

  cfg_t    cfgShadow;
  edges_t  edges;
  winCtl_t winCtl;
  logic    windowOpen;

  vsreject_cfg cfg_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (cfgWrEn),
    .wrData    (cfgWrData),
    .cfgShadow (cfgShadow)
  );

  vsreject_ctrl ctrl_i (
    .cfgShadow  (cfgShadow),
    .edges      (edges),
    .clampNow   (clampIn),
    .calNow     (calIn),
    .windowOpen (windowOpen),
    .winCtl     (winCtl)
  );

  vsreject_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .clampIn    (clampIn),
    .calIn      (calIn),
    .winCtl     (winCtl),
    .edges      (edges),
    .windowOpen (windowOpen),
    .clampEn    (clampEn),
    .calWindow  (calWindow),
    .overlapErr (overlapErr)
  );

  assign rejectOut = windowOpen;

endmodule

// File: rtl/vsreject_chk.sv
module vsreject_chk
  import vsreject_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [CFG_W-1:0] cfgWrData,
  input logic             clampIn,
  input logic             calIn,
  input logic             rejectOut,
  input logic             clampEn,
  input logic             calWindow,
  input logic             overlapErr
);

  logic             pastValid;
  logic [CFG_W-1:0] mCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      mCfg      <= '0;
    end else begin
      pastValid <= 1'b1;
      if (cfgWrEn) mCfg <= cfgWrData;
    end
  end

  assert_clamp_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (clampEn == $past(clampIn)));

  assert_cal_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (calWindow == $past(calIn)));

  assert_overlap_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clampIn && calIn) |=> overlapErr);

  assert_overlap_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overlapErr |=> overlapErr);

  assert_no_strobe_overlap_R11: assert property (@(posedge clk) disable iff (!rstN)
    rejectOut |-> (!clampEn && !calWindow));

  // R4 and R5: the window opens on the selected strobe's falling edge.
  assert_open_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rejectOut) |-> ($past(mCfg[CFG_SWAP_BIT]) ? $fell(clampEn) : $fell(calWindow)));

  assert_open_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rejectOut) |-> $past(mCfg[CFG_REJ_BIT]));

  assert_open_not_oneshot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rejectOut) |-> !$past(mCfg[CFG_ONESHOT_BIT]));

endmodule

bind vsreject_top vsreject_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .clampIn    (clampIn),
  .calIn      (calIn),
  .rejectOut  (rejectOut),
  .clampEn    (clampEn),
  .calWindow  (calWindow),
  .overlapErr (overlapErr)
);

// File: tb/vsreject_tb_top.sv
`timescale 1ns/1ps
module vsreject_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrEn;
  logic [2:0] cfgWrData;
  logic       clampIn;
  logic       calIn;
  logic       rejectOut;
  logic       clampEn;
  logic       calWindow;
  logic       overlapErr;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  vsreject_top dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .clampIn    (clampIn),
    .calIn      (calIn),
    .rejectOut  (rejectOut),
    .clampEn    (clampEn),
    .calWindow  (calWindow),
    .overlapErr (overlapErr)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive inputs at the falling edge, then sample 2 ns after the next rising edge.
  task automatic cyc(input logic c, input logic a);
    @(negedge clk);
    clampIn = c;
    calIn   = a;
    @(posedge clk);
    #2;
  endtask

  task automatic wrCfg(input logic [2:0] d);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = d;
    @(posedge clk);
    #2;
    cfgWrEn   = 1'b0;
  endtask

  task automatic doReset();
    rstN      = 1'b0;
    cfgWrEn   = 1'b0;
    cfgWrData = 3'b000;
    clampIn   = 1'b0;
    calIn     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // R1: reset state
  task automatic testReset();
    doReset();
    check("R1", "rejectOut", rejectOut, 1'b0);
    check("R1", "clampEn", clampEn, 1'b0);
    check("R1", "calWindow", calWindow, 1'b0);
    check("R1", "overlapErr", overlapErr, 1'b0);
    // A configuration of 000 means rejection is off: a full line opens nothing.
    cyc(0, 1); cyc(0, 0);
    check("R1", "reject with reset config", rejectOut, 1'b0);
  endtask

  // R4, R2, R11: normal roles
  task automatic testNormal();
    doReset();
    wrCfg(3'b001);
    cyc(0, 1);
    check("R2", "calWindow follows calIn", calWindow, 1'b1);
    check("R4", "no reject during cal", rejectOut, 1'b0);
    cyc(0, 1);
    cyc(0, 0);
    check("R4", "reject opens on cal fall", rejectOut, 1'b1);
    check("R4", "calWindow low at open", calWindow, 1'b0);
    cyc(0, 0);
    check("R4", "reject held in shift", rejectOut, 1'b1);
    cyc(1, 0);
    check("R4", "reject closes on clamp rise", rejectOut, 1'b0);
    check("R2", "clampEn follows clampIn", clampEn, 1'b1);
    check("R11", "reject vs clamp strobe", rejectOut & clampEn, 1'b0);
    cyc(0, 0);
    check("R4", "clamp fall does not open", rejectOut, 1'b0);
    cyc(0, 0);
    check("R2", "clampEn low after pulse", clampEn, 1'b0);
  endtask

  // R5: swapped roles
  task automatic testSwap();
    doReset();
    wrCfg(3'b011);
    cyc(1, 0);
    cyc(0, 0);
    check("R5", "reject opens on clamp fall", rejectOut, 1'b1);
    cyc(0, 0);
    cyc(0, 1);
    check("R5", "reject closes on cal rise", rejectOut, 1'b0);
    cyc(0, 0);
    check("R5", "cal fall does not open when swapped", rejectOut, 1'b0);
  endtask

  // R6 and R7: inhibited window
  task automatic testDisabled();
    doReset();
    wrCfg(3'b000);
    cyc(0, 1); cyc(0, 0); cyc(0, 0);
    check("R6", "reject stays low when disabled", rejectOut, 1'b0);
    wrCfg(3'b101);
    cyc(0, 1); cyc(0, 0); cyc(0, 0);
    check("R7", "reject stays low in one-shot mode", rejectOut, 1'b0);
    wrCfg(3'b001);
    cyc(0, 1); cyc(0, 0);
    check("R7", "reject resumes after one-shot cleared", rejectOut, 1'b1);
  endtask

  // R8: startup partial line
  task automatic testStartup();
    doReset();
    wrCfg(3'b001);
    cyc(0, 0); cyc(0, 0);
    check("R8", "no reject without opener", rejectOut, 1'b0);
    cyc(1, 0); cyc(0, 0); cyc(0, 0);
    check("R8", "closer alone does not open", rejectOut, 1'b0);
    cyc(0, 1); cyc(0, 0);
    check("R8", "first full opener opens", rejectOut, 1'b1);
  endtask

  // R9: writes during an open window
  task automatic testMidWrite();
    doReset();
    wrCfg(3'b001);
    cyc(0, 1); cyc(0, 0);
    check("R9", "window open before write", rejectOut, 1'b1);
    wrCfg(3'b000);
    check("R9", "disable write keeps window", rejectOut, 1'b1);
    cyc(0, 0);
    check("R9", "window still open", rejectOut, 1'b1);
    cyc(1, 0);
    check("R9", "original closer closes", rejectOut, 1'b0);
    cyc(0, 0); cyc(0, 1); cyc(0, 0);
    check("R9", "disable takes effect next line", rejectOut, 1'b0);
    // Swap written mid-window: the current window still closes on the clamp rise,
    // and the clamp fall then opens the next window.
    wrCfg(3'b001);
    cyc(0, 1); cyc(0, 0);
    check("R9", "window reopened", rejectOut, 1'b1);
    wrCfg(3'b011);
    check("R9", "swap write keeps window", rejectOut, 1'b1);
    cyc(1, 0);
    check("R9", "clamp rise closes window", rejectOut, 1'b0);
    cyc(0, 0);
    check("R9", "swap used at next opening", rejectOut, 1'b1);
    cyc(0, 1);
    check("R9", "cal rise closes swapped window", rejectOut, 1'b0);
  endtask

  // R10: opener reasserts before closer
  task automatic testReopen();
    doReset();
    wrCfg(3'b001);
    cyc(0, 1); cyc(0, 0);
    check("R10", "window open", rejectOut, 1'b1);
    cyc(0, 1);
    check("R10", "opener rise closes window", rejectOut, 1'b0);
    check("R11", "reject vs cal strobe", rejectOut & calWindow, 1'b0);
    cyc(0, 0);
    check("R10", "fall after re-pulse opens again", rejectOut, 1'b1);
  endtask

  // R3: overlap flag
  task automatic testOverlap();
    doReset();
    cyc(1, 0);
    check("R3", "no flag for clamp alone", overlapErr, 1'b0);
    cyc(1, 1);
    check("R3", "flag set after overlap", overlapErr, 1'b1);
    cyc(0, 0); cyc(0, 1); cyc(0, 0);
    check("R3", "flag sticky", overlapErr, 1'b1);
    doReset();
    check("R3", "flag cleared by reset", overlapErr, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testNormal();
    testSwap();
    testDisabled();
    testStartup();
    testMidWrite();
    testReopen();
    testOverlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule